// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to the point where it accepts normal commands. It owns the command and address pins (chip select, row strobe, column strobe, write enable, clock enable, bank address and address) only during bring-up. It issues a fixed series of one-cycle commands with NOP on every cycle between them, and it counts out the minimum gaps that the memory needs. When the sequence is over it raises `initDone`. A memory controller then takes over the bus.

The mode-register images come from configuration inputs: burst length, CAS latency, write recovery, output drive strength and on-die termination. The sequence runs as follows. Clock enable is held low for a stable-power interval, then raised. After a NOP wait, the sequencer programs extended registers 2 and 3, then the extended register with the DLL enabled, then the main register with DLL reset. It follows with a precharge of all banks and two refreshes. It then writes the main register again without DLL reset, and finishes with the OCD-default and OCD-exit writes to the extended register. Readiness is also held back until the DLL has had its lock time since the DLL-reset command.

Every wait is a parameter counted in clock cycles. A reset at any time restarts the whole sequence.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, and after it falls until CKE rises, `ddrCke` is 0 and the bus carries NOP. NOP means CS#=0, RAS#=1, CAS#=1, WE#=1, with address and bank address 0. `initDone` is 0 during this time. `ddrCke` rises on the STABLE_CYC-th rising clock edge after `rst` falls.
- R2: The first non-NOP command appears exactly PWR_NOP_CYC cycles after `ddrCke` rises. Only NOP is driven in between.
- R3: Exactly ten commands are issued, in this order:
  - LOAD MODE to bank 2, then to bank 3, then to bank 1, then to bank 0.
  - PRECHARGE ALL.
  - REFRESH, then REFRESH again.
  - LOAD MODE to bank 0, then to bank 1, then to bank 1 again.
  - Encodings (RAS#,CAS#,WE# with CS#=0): LOAD MODE 000, PRECHARGE 010, REFRESH 001.
- R4: Each command lasts one cycle. The next command follows exactly MRD_CYC cycles after a LOAD MODE, RP_CYC cycles after the precharge, and RFC_CYC cycles after a refresh.
- R5: A main-register write carries:
  - burst length on A2:A0, CAS latency on A6:A4 and write recovery on A11:A9;
  - A8=1 on the first (DLL reset) write and A8=0 on the second;
  - every other address bit 0.
- R6: An extended-register write (bank 1) carries:
  - A0=0 (DLL enabled), drive strength on A1, termination select bit 0 on A2 and bit 1 on A6;
  - A9:A7=111 on the OCD-default write and 000 on the other two;
  - every other bit 0.
  - Both the bank 2 write and the bank 3 write carry an all-zero address.
- R7: The precharge drives only A10 high, with bank address 0. Each refresh drives address and bank address 0.
- R8: Let M be the cycle of the DLL-reset write and E the cycle of the OCD-exit write. `initDone` rises exactly at max(E+MRD_CYC, M+DLL_CYC). `ddrCke` stays high from M onward.
- R9: Once `initDone` is high, it stays high, `ddrCke` stays high and only NOP is issued, until reset.
- R10: A reset asserted partway through the sequence restarts it from the CKE-low state, and the whole sequence is repeated with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Asynchronous active-high reset |
| cfgBurstLen | input | 3 | Burst-length code for A2:A0 |
| cfgCasLat | input | 3 | CAS-latency code for A6:A4 |
| cfgWriteRec | input | 3 | Write-recovery code for A11:A9 |
| cfgDrvReduced | input | 1 | Reduced output drive (A1 of extended register) |
| cfgRttSel | input | 2 | Termination select (bit1 to A6, bit0 to A2) |
| ddrCke | output | 1 | Clock enable |
| ddrCsN | output | 1 | Chip select, active low |
| ddrRasN | output | 1 | Row strobe, active low |
| ddrCasN | output | 1 | Column strobe, active low |
| ddrWeN | output | 1 | Write enable, active low |
| ddrBa | output | BA_W | Bank address |
| ddrAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Device ready for normal commands |

## Verification
Any fault in the step register or the gap counter shows on the pins at the next command slot, so it surfaces within one gap of the fault. A skipped or repeated step changes the command count or the bank-address order. A counter that loads the wrong value moves a command by a whole number of cycles. A wrong image select corrupts a single address bit in one LOAD MODE. A DLL window that was never armed or is too short moves the rise of `initDone`, which is measured to the exact cycle. Every run is therefore compared cycle for cycle against a timeline computed from the parameters. The comparison is repeated across configuration codes and after resets injected at many points in the sequence.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_CKE_LOW, ST_EMR2, ST_EMR3, ST_EMR_DLL, ST_MR_RST, ST_PREALL,
    ST_REF1, ST_REF2, ST_MR_RUN, ST_EMR_OCD, ST_EMR_EXIT, ST_FINISH, ST_DONE
  } step_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} cmd_e;

  typedef enum logic [2:0] {
    IMG_ZERO, IMG_EMR2, IMG_EMR3, IMG_EMR_BASE, IMG_MR_RST, IMG_MR_RUN, IMG_EMR_OCD
  } img_e;

  typedef enum logic [1:0] {GAP_PWR, GAP_MRD, GAP_RP, GAP_RFC} gap_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic fire;
    cmd_e cmd;
    img_e img;
    logic loadGap;
    gap_e gapSel;
    logic ckeOn;
    logic armDll;
  } strb_t;

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  gapZero,
  input  logic  dllDone,
  output strb_t strb,
  output logic  initDone
);

  step_e st, stNext;

  // per-step command descriptor
  logic  isCmd;
  cmd_e  stepCmd;
  img_e  stepImg;
  gap_e  stepGap;
  step_e stepAfter;

  always_comb begin
    isCmd     = 1'b1;
    stepCmd   = CMD_MRS;
    stepImg   = IMG_ZERO;
    stepGap   = GAP_MRD;
    stepAfter = st;
    case (st)
      ST_EMR2:     begin stepImg = IMG_EMR2;     stepAfter = ST_EMR3;     end
      ST_EMR3:     begin stepImg = IMG_EMR3;     stepAfter = ST_EMR_DLL;  end
      ST_EMR_DLL:  begin stepImg = IMG_EMR_BASE; stepAfter = ST_MR_RST;   end
      ST_MR_RST:   begin stepImg = IMG_MR_RST;   stepAfter = ST_PREALL;   end
      ST_PREALL:   begin stepCmd = CMD_PRE; stepGap = GAP_RP;  stepAfter = ST_REF1; end
      ST_REF1:     begin stepCmd = CMD_REF; stepGap = GAP_RFC; stepAfter = ST_REF2; end
      ST_REF2:     begin stepCmd = CMD_REF; stepGap = GAP_RFC; stepAfter = ST_MR_RUN; end
      ST_MR_RUN:   begin stepImg = IMG_MR_RUN;   stepAfter = ST_EMR_OCD;  end
      ST_EMR_OCD:  begin stepImg = IMG_EMR_OCD;  stepAfter = ST_EMR_EXIT; end
      ST_EMR_EXIT: begin stepImg = IMG_EMR_BASE; stepAfter = ST_FINISH;   end
      default:     begin isCmd = 1'b0; stepCmd = CMD_NOP; end
    endcase
  end

  always_comb begin
    strb   = '0;
    stNext = st;
    case (st)
      ST_CKE_LOW: if (gapZero) begin
        strb.ckeOn   = 1'b1;
        strb.loadGap = 1'b1;
        strb.gapSel  = GAP_PWR;
        stNext       = ST_EMR2;
      end
      ST_FINISH: if (gapZero && dllDone) stNext = ST_DONE;
      ST_DONE: ;
      default: if (isCmd && gapZero) begin
        strb.fire    = 1'b1;
        strb.cmd     = stepCmd;
        strb.img     = stepImg;
        strb.loadGap = 1'b1;
        strb.gapSel  = stepGap;
        strb.armDll  = (st == ST_MR_RST);
        stNext       = stepAfter;
      end
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st       <= ST_CKE_LOW;
      initDone <= 1'b0;
    end else begin
      st       <= stNext;
      initDone <= (stNext == ST_DONE);
    end
  end

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    initDone |-> !strb.fire && !strb.loadGap);

  assert_done_after_dll_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> $past(dllDone));

  assert_fire_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    strb.fire |-> gapZero);

endmodule

// File: rtl/ddr2_init_dp.sv
module ddr2_init_dp
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 3,
  parameter int STABLE_CYC  = 100,
  parameter int PWR_NOP_CYC = 160,
  parameter int MRD_CYC     = 2,
  parameter int RP_CYC      = 5,
  parameter int RFC_CYC     = 52,
  parameter int DLL_CYC     = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  strb_t             strb,
  input  logic [2:0]        cfgBurstLen,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgWriteRec,
  input  logic              cfgDrvReduced,
  input  logic [1:0]        cfgRttSel,
  output logic              gapZero,
  output logic              dllDone,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int MAX_A   = (STABLE_CYC > PWR_NOP_CYC) ? STABLE_CYC : PWR_NOP_CYC;
  localparam int MAX_B   = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int MAX_C   = (MAX_B > MRD_CYC) ? MAX_B : MRD_CYC;
  localparam int GAP_MAX = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int DLL_W   = $clog2(DLL_CYC + 1);

  // gap counter: a command may fire when it reaches zero
  logic [CNT_W-1:0] gapCnt, gapVal;

  always_comb begin
    case (strb.gapSel)
      GAP_PWR: gapVal = CNT_W'(PWR_NOP_CYC - 1);
      GAP_MRD: gapVal = CNT_W'(MRD_CYC - 1);
      GAP_RP:  gapVal = CNT_W'(RP_CYC - 1);
      default: gapVal = CNT_W'(RFC_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                gapCnt <= CNT_W'(STABLE_CYC - 1);
    else if (strb.loadGap)  gapCnt <= gapVal;
    else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
  end
  assign gapZero = (gapCnt == '0);

  // DLL lock window, armed by the DLL-reset write
  logic [DLL_W-1:0] dllCnt;
  logic             dllArmed;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dllCnt   <= '0;
      dllArmed <= 1'b0;
    end else if (strb.armDll) begin
      dllCnt   <= DLL_W'(DLL_CYC - 1);
      dllArmed <= 1'b1;
    end else if (dllCnt != '0) begin
      dllCnt   <= dllCnt - 1'b1;
    end
  end
  assign dllDone = dllArmed && (dllCnt == '0);

  // mode-register image builder
  logic [ADDR_W-1:0] imgAddr;
  logic [BA_W-1:0]   imgBa;

  always_comb begin
    imgAddr = '0;
    imgBa   = '0;
    case (strb.img)
      IMG_EMR2: imgBa = BA_W'(2);
      IMG_EMR3: imgBa = BA_W'(3);
      IMG_MR_RST, IMG_MR_RUN: begin
        imgAddr[2:0]  = cfgBurstLen;
        imgAddr[6:4]  = cfgCasLat;
        imgAddr[8]    = (strb.img == IMG_MR_RST);
        imgAddr[11:9] = cfgWriteRec;
      end
      IMG_EMR_BASE, IMG_EMR_OCD: begin
        imgBa         = BA_W'(1);
        imgAddr[1]    = cfgDrvReduced;
        imgAddr[2]    = cfgRttSel[0];
        imgAddr[6]    = cfgRttSel[1];
        imgAddr[9:7]  = {3{strb.img == IMG_EMR_OCD}};
      end
      default: ;
    endcase
    if (strb.cmd == CMD_PRE) begin
      imgAddr     = '0;
      imgAddr[10] = 1'b1;
      imgBa       = '0;
    end else if (strb.cmd == CMD_REF) begin
      imgAddr = '0;
      imgBa   = '0;
    end
  end

  function automatic logic [2:0] cmdPins(cmd_e c);
    case (c)
      CMD_MRS: return 3'b000;
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cke                <= 1'b0;
      csN                <= 1'b0;
      {rasN, casN, weN}  <= 3'b111;
      addr               <= '0;
      ba                 <= '0;
    end else begin
      if (strb.ckeOn) cke <= 1'b1;
      csN <= 1'b0;
      if (strb.fire) begin
        {rasN, casN, weN} <= cmdPins(strb.cmd);
        addr              <= imgAddr;
        ba                <= imgBa;
      end else begin
        {rasN, casN, weN} <= 3'b111;
        addr              <= '0;
        ba                <= '0;
      end
    end
  end

  assert_no_cmd_cke_low_R1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (rasN && casN && weN));

  assert_cke_held_dll_R8: assert property (@(posedge clk) disable iff (rst)
    dllArmed |-> cke);

  assert_one_cycle_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    !(rasN && casN && weN) |=> (rasN && casN && weN));

  assert_pre_a10_R7: assert property (@(posedge clk) disable iff (rst)
    ({rasN, casN, weN} == 3'b010) |-> (addr[10] && ba == '0));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 3,
  parameter int STABLE_CYC  = 100,
  parameter int PWR_NOP_CYC = 160,
  parameter int MRD_CYC     = 2,
  parameter int RP_CYC      = 5,
  parameter int RFC_CYC     = 52,
  parameter int DLL_CYC     = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfgBurstLen,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgWriteRec,
  input  logic              cfgDrvReduced,
  input  logic [1:0]        cfgRttSel,
  output logic              ddrCke,
  output logic              ddrCsN,
  output logic              ddrRasN,
  output logic              ddrCasN,
  output logic              ddrWeN,
  output logic [BA_W-1:0]   ddrBa,
  output logic [ADDR_W-1:0] ddrAddr,
  output logic              initDone
);

  strb_t strb;
  logic  gapZero, dllDone;

  ddr2_init_ctrl ctrl_i (
    .clk(clk), .rst(rst), .gapZero(gapZero), .dllDone(dllDone),
    .strb(strb), .initDone(initDone)
  );

  ddr2_init_dp #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .STABLE_CYC(STABLE_CYC),
    .PWR_NOP_CYC(PWR_NOP_CYC), .MRD_CYC(MRD_CYC), .RP_CYC(RP_CYC),
    .RFC_CYC(RFC_CYC), .DLL_CYC(DLL_CYC)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb),
    .cfgBurstLen(cfgBurstLen), .cfgCasLat(cfgCasLat), .cfgWriteRec(cfgWriteRec),
    .cfgDrvReduced(cfgDrvReduced), .cfgRttSel(cfgRttSel),
    .gapZero(gapZero), .dllDone(dllDone),
    .cke(ddrCke), .csN(ddrCsN), .rasN(ddrRasN), .casN(ddrCasN), .weN(ddrWeN),
    .ba(ddrBa), .addr(ddrAddr)
  );

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb_top;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 14;
  localparam int BA_W   = 3;
  localparam int STABLE = 20;
  localparam int PWR    = 30;
  localparam int MRD    = 2;
  localparam int RP     = 4;
  localparam int RFC    = 9;
  localparam int DLLC   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfgBurstLen = 3'd2, cfgCasLat = 3'd3, cfgWriteRec = 3'd1;
  logic cfgDrvReduced = 1'b0;
  logic [1:0] cfgRttSel = 2'd0;
  logic ddrCke, ddrCsN, ddrRasN, ddrCasN, ddrWeN, initDone;
  logic [BA_W-1:0] ddrBa;
  logic [ADDR_W-1:0] ddrAddr;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_P/2) clk = ~clk;

  ddr2_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .STABLE_CYC(STABLE), .PWR_NOP_CYC(PWR),
    .MRD_CYC(MRD), .RP_CYC(RP), .RFC_CYC(RFC), .DLL_CYC(DLLC)
  ) dut_i (
    .clk(clk), .rst(rst), .cfgBurstLen(cfgBurstLen), .cfgCasLat(cfgCasLat),
    .cfgWriteRec(cfgWriteRec), .cfgDrvReduced(cfgDrvReduced), .cfgRttSel(cfgRttSel),
    .ddrCke(ddrCke), .ddrCsN(ddrCsN), .ddrRasN(ddrRasN), .ddrCasN(ddrCasN),
    .ddrWeN(ddrWeN), .ddrBa(ddrBa), .ddrAddr(ddrAddr), .initDone(initDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isNop();
    return (ddrCsN == 1'b0) && ddrRasN && ddrCasN && ddrWeN;
  endfunction

  function automatic int mrImage(input bit dllRst);
    return (int'(cfgWriteRec) << 9) | (int'(dllRst) << 8) |
           (int'(cfgCasLat) << 4) | int'(cfgBurstLen);
  endfunction

  function automatic int emrImage(input bit ocd);
    return ((ocd ? 7 : 0) << 7) | (int'(cfgRttSel[1]) << 6) |
           (int'(cfgRttSel[0]) << 2) | (int'(cfgDrvReduced) << 1);
  endfunction

  // one bring-up; abortAt > 0 reasserts reset at that cycle without checking
  task automatic runOne(input int idx, input int abortAt, input string tag);
    int logCyc[16], logKind[16], logBa[16], logAddr[16];
    int expKind[10], expBa[10], expAddr[10], expGap[10];
    int k = 0, ckeRise = -1, nCmd = 0, doneK = -1;
    bit cmdCkeLow = 0, ckeDrop = 0, postBad = 0;
    cfgBurstLen   = (idx % 2 == 0) ? 3'd2 : 3'd3;
    cfgCasLat     = 3'(3 + (idx % 4));
    cfgWriteRec   = 3'(1 + (idx % 5));
    cfgDrvReduced = idx[0] ^ idx[2];
    cfgRttSel     = 2'(idx / 2);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    if (abortAt == 0) begin
      chk({"R1 reset cke ", tag}, int'(ddrCke), 0);
      chk({"R1 reset nop ", tag}, int'(isNop()), 1);
      chk({"R1 reset bus ", tag}, int'(ddrAddr) + int'(ddrBa), 0);
      chk({"R1 reset done ", tag}, int'(initDone), 0);
    end
    rst = 1'b0;
    while (k < 1000) begin
      @(negedge clk);
      k++;
      if (abortAt != 0 && k == abortAt) return;
      if (ckeRise < 0 && ddrCke) ckeRise = k;
      if (!ddrCke && !isNop()) cmdCkeLow = 1;
      if (!isNop()) begin
        if (nCmd < 16) begin
          logCyc[nCmd]  = k;
          logKind[nCmd] = int'({ddrRasN, ddrCasN, ddrWeN});
          logBa[nCmd]   = int'(ddrBa);
          logAddr[nCmd] = int'(ddrAddr);
        end
        nCmd++;
      end
      if (nCmd >= 4 && !ddrCke) ckeDrop = 1;
      if (doneK >= 0 && (!isNop() || !initDone || !ddrCke)) postBad = 1;
      if (initDone && doneK < 0) doneK = k;
      if (doneK >= 0 && k >= doneK + 16) break;
    end
    if (abortAt != 0) return;
    expKind = '{0, 0, 0, 0, 2, 1, 1, 0, 0, 0};
    expBa   = '{2, 3, 1, 0, 0, 0, 0, 0, 1, 1};
    expAddr = '{0, 0, emrImage(0), mrImage(1), 1 << 10, 0, 0, mrImage(0), emrImage(1), emrImage(0)};
    expGap  = '{MRD, MRD, MRD, MRD, RP, RFC, RFC, MRD, MRD, MRD};
    chk({"R1 cke rise edge ", tag}, ckeRise, STABLE);
    chk({"R1 no command while cke low ", tag}, int'(cmdCkeLow), 0);
    chk({"R3 command count ", tag}, nCmd, 10);
    if (nCmd == 10) begin
      chk({"R2 first command delay ", tag}, logCyc[0] - ckeRise, PWR);
      for (int i = 0; i < 10; i++) begin
        chk({"R3 kind ", tag}, logKind[i], expKind[i]);
        chk({"R3 bank ", tag}, logBa[i], expBa[i]);
        if (i == 3 || i == 7)      chk({"R5 main image ", tag}, logAddr[i], expAddr[i]);
        else if (i == 4 || i == 5 || i == 6) chk({"R7 pre/ref addr ", tag}, logAddr[i], expAddr[i]);
        else                       chk({"R6 ext image ", tag}, logAddr[i], expAddr[i]);
        if (i < 9) chk({"R4 gap ", tag}, logCyc[i+1] - logCyc[i], expGap[i]);
      end
      chk({"R8 done cycle ", tag}, doneK,
          (logCyc[9] + MRD > logCyc[3] + DLLC) ? logCyc[9] + MRD : logCyc[3] + DLLC);
    end
    chk({"R8 cke held after dll reset ", tag}, int'(ckeDrop), 0);
    chk({"R9 idle after done ", tag}, int'(postBad), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int idx = 0; idx < 24; idx++) begin
      if (idx % 3 == 1) begin
        runOne(idx, 10 + idx * 5, "");
        runOne(idx, 0, "R10 restart");
      end else begin
        runOne(idx, 0, "sweep");
      end
    end
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule